// File: doc/BRIEF.md
# Overlapping Two-Pattern Serial Match Detector

This block watches a serial bit stream, one bit per clock, and raises a match flag in the same cycle as the bit that completes either of two four-bit patterns: four ones in a row (`1111`) or a one, two zeros and a one (`1001`). Matches may overlap. A long run of ones keeps the flag high on every bit from the fourth one onward. The closing one of a `1001` also counts as the opening one of any later pattern.

The detector is a six-state Mealy machine. Each state records the longest useful prefix of either pattern seen so far: nothing, `1`, `10`, `11`, `100` or `111`. The state is the only register. The match flag is decoded combinationally from the state and the present input bit, so it follows the input within the cycle. A synchronous active-low reset returns the machine to the empty-prefix state and discards all history.

Top module: `dual_seq_detector`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, the machine enters the empty-prefix state. In the following cycle `match` is 0 whatever `bit_in` is, and bits seen before the reset never contribute to a match.
- R2: `match` is 1 in a cycle where `bit_in` is 1 and the three bits accepted at the three previous edges since reset were 1, 1, 1 (pattern `1111`).
- R3: `match` is 1 in a cycle where `bit_in` is 1 and the three bits accepted at the three previous edges since reset were 1, 0, 0 (pattern `1001`).
- R4: Overlapping matches each count. A run of N ≥ 4 ones raises `match` on the 4th through Nth ones. The stream `1001001` raises `match` on the 4th and 7th bits.
- R5: In every other cycle `match` is 0. In particular `match` is never 1 while `bit_in` is 0.
- R6: `match` is a combinational function of the stored state and `bit_in`. It changes within a cycle when `bit_in` changes, with no clock edge in between.
- R7: The closing 1 of a `1001` match serves as the first 1 of a following `1111`. After reset, the stream `1001111` raises `match` on the 4th and 7th bits only.
- R8: After reset, the stream `010111100110011111` produces the match stream `000000100100010011`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial input bit, one per cycle |
| match | output | 1 | High in the cycle whose input bit completes `1111` or `1001` |

## Verification
Two things can happen on the same input bit. A bit can close one pattern and at the same time open or extend another: the closing 1 of `1001` is also a first 1, and every 1 in a long run both closes a `1111` and keeps the next one alive. The bench provokes this with directed streams such as `1001111`, `1001001` and long runs of ones, followed by a long pseudo-random stream with occasional resets. Every cycle's `match` is compared against a reference that looks only at a queue of the last accepted bits and the present input. A separate check toggles `bit_in` within one cycle to confirm that `match` follows it combinationally.

// File: rtl/det_pkg.sv
// Shared types for the two-pattern serial detector.
// Each state names the longest pattern prefix currently held.
package det_pkg;
    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,  // no useful prefix
        ST_G1   = 3'd1,  // seen 1
        ST_G10  = 3'd2,  // seen 10
        ST_G11  = 3'd3,  // seen 11
        ST_G100 = 3'd4,  // seen 100
        ST_G111 = 3'd5   // seen 111
    } det_state_t;
endpackage

// File: rtl/det_next_state.sv
// Next-state function of the detector.
// Assumes the current state is one of the six legal codes; any other code
// falls back to the idle state.
module det_next_state
    import det_pkg::*;
(
    input  det_state_t cur_state,
    input  logic       bit_in,
    output det_state_t nxt_state
);
    // Purpose: pick the longest surviving prefix after accepting bit_in.
    always_comb begin
        unique case (cur_state)
            ST_IDLE: nxt_state = bit_in ? ST_G1   : ST_IDLE;
            ST_G1:   nxt_state = bit_in ? ST_G11  : ST_G10;
            ST_G10:  nxt_state = bit_in ? ST_G1   : ST_G100;
            ST_G11:  nxt_state = bit_in ? ST_G111 : ST_G10;
            ST_G100: nxt_state = bit_in ? ST_G1   : ST_IDLE;
            ST_G111: nxt_state = bit_in ? ST_G111 : ST_G10;
            default: nxt_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/det_output_decode.sv
// Mealy output decode: flags a completed pattern from state and input.
// Assumes the state is legal. Purely combinational with no storage.
module det_output_decode
    import det_pkg::*;
(
    input  det_state_t cur_state,
    input  logic       bit_in,
    output logic       match
);
    // Purpose: a 1 arriving after 100 or 111 completes a pattern.
    always_comb begin
        match = 1'b0;
        if (bit_in) begin
            match = (cur_state == ST_G100) || (cur_state == ST_G111);
        end
    end
endmodule

// File: rtl/det_state_reg.sv
// State register with synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module det_state_reg
    import det_pkg::*;
#(
    parameter det_state_t RESET_STATE = ST_IDLE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  det_state_t nxt_state,
    output det_state_t cur_state
);
    // Purpose: hold the prefix state, loading the reset state when rst_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= RESET_STATE;
        else        cur_state <= nxt_state;
    end
endmodule

// File: rtl/dual_seq_detector.sv
// Top level of the overlapping 1111 / 1001 serial detector.
// One input bit is accepted per rising edge. The match flag is combinational
// (Mealy) from the registered prefix state and the present bit.
module dual_seq_detector
    import det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic match
);
    det_state_t cur_state;
    det_state_t nxt_state;

    det_next_state u_next (
        .cur_state (cur_state),
        .bit_in    (bit_in),
        .nxt_state (nxt_state)
    );

    det_state_reg #(.RESET_STATE(ST_IDLE)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    det_output_decode u_out (
        .cur_state (cur_state),
        .bit_in    (bit_in),
        .match     (match)
    );

    // R1: a reset edge leaves the machine in the empty-prefix state.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_state == ST_IDLE));

    // R5: both patterns end in 1, so a flag with a 0 input is wrong.
    p_no_match_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> bit_in);

    // R2: a 1 after three stored ones must flag.
    p_ones_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_G111 && bit_in) |-> match);

    // R4: a run of ones keeps the machine in the three-ones state.
    p_ones_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_G111 && bit_in) |=> (cur_state == ST_G111));

    // R7: the closing 1 of 1001 is retained as a fresh single-1 prefix.
    p_share_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_G100 && bit_in) |=> (cur_state == ST_G1));

    // R3: the closing 1 of 1001 must flag.
    p_tail_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_G100 && bit_in) |-> match);
endmodule

// File: tb/test_dual_seq_detector.sv
module test_dual_seq_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic match;

    int n_cmp = 0;
    int n_bad = 0;
    bit valid = 1'b0;
    bit hist[$];
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_seq_detector i_dual_seq_detector (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (bit_in),
        .match  (match)
    );

    function automatic bit model(input bit b, output string req);
        bit [3:0] w;
        req = "R5";
        if (hist.size() < 3) return 1'b0;
        w = {hist[hist.size()-3], hist[hist.size()-2], hist[hist.size()-1], b};
        if (w == 4'b1111) begin req = "R2"; return 1'b1; end
        if (w == 4'b1001) begin req = "R3"; return 1'b1; end
        return 1'b0;
    endfunction

    task automatic compare(input bit exp, input string req, input string tag);
        n_cmp++;
        if (match !== exp) begin
            n_bad++;
            $display("FAIL %s/%s: match=%b expected=%b at %0t", req, tag, match, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check mid low phase, update model after the edge.
    task automatic step(input bit b, input bit r, input string tag, input bit mealy = 1'b0);
        string req;
        bit exp;
        @(negedge clk);
        rst_n = r;
        if (mealy && valid) begin
            bit_in = ~b;
            #2;
            exp = model(~b, req);
            compare(exp, "R6", tag);
        end
        bit_in = b;
        #3;
        if (valid) begin
            exp = model(b, req);
            compare(exp, req, tag);
        end
        @(posedge clk);
        #1;
        valid = 1'b1;
        if (!r) hist.delete();
        else begin
            hist.push_back(b);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    endtask

    task automatic run_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) step(s[i] == "1", 1'b1, tag);
    endtask

    // Directed stream with its own literal expected output (R8).
    task automatic run_golden(input string s, input string zs);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            rst_n = 1'b1;
            bit_in = (s[i] == "1");
            #5;
            n_cmp++;
            if (match !== (zs[i] == "1")) begin
                n_bad++;
                $display("FAIL R8: bit %0d match=%b expected=%b", i, match, zs[i] == "1");
            end
            @(posedge clk);
            #1;
            hist.push_back(s[i] == "1");
            if (hist.size() > 3) void'(hist.pop_front());
        end
    endtask

    initial begin
        fork
            begin
                // R1: reset cycles, then reset state seen with x=1
                step(1'b1, 1'b0, "R1");
                step(1'b1, 1'b0, "R1");
                run_golden("010111100110011111", "000000100100010011");
                step(1'b0, 1'b0, "R1");
                run_str("011111111", "R4");
                step(1'b0, 1'b0, "R1");
                run_str("1001001", "R4");
                step(1'b0, 1'b0, "R1");
                run_str("1001111", "R7");
                run_str("0111", "R1");
                step(1'b1, 1'b0, "R1");
                run_str("1111", "R1");
                run_str("0100", "R6");
                step(1'b1, 1'b1, "R6", 1'b1);
                run_str("11", "R6");
                step(1'b1, 1'b1, "R6", 1'b1);
                step(1'b0, 1'b1, "R6", 1'b1);
                for (int k = 0; k < 3000; k++) begin
                    int v = $urandom_range(0, 99);
                    step(v < 55, v != 7, "R5", v == 11);
                end
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL watchdog: run did not complete");
                end
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule